// File: doc/BRIEF.md
# Single-Bit Alias Bus Bridge

This bridge sits between one bus master and the memory bus. Two address windows are treated as alias regions: every 32-bit word inside a window stands for exactly one bit of a backing region. A read of an alias word returns that bit as 0 or 1. A write sets or clears only that bit. The write is an indivisible read-modify-write, and the memory bus stays locked from its read phase to its write phase.

Byte, halfword and word accesses are supported. The access size sets the width of the backing unit, its alignment and the range of the bit index. Any access that misses both windows goes to the master port with its address, size, direction and data unchanged, and the memory response comes straight back.

Both ports use a request/done handshake. The master holds a request until `s_done` pulses for one cycle. Memory answers a request with a one-cycle `m_done`. For reads, memory returns the addressed unit zero-extended into the low lanes (little-endian).

Top module: `bb_bridge`

## Requirements
- R1: An address whose bits [31:25] equal those of 0x22000000 or 0x42000000 is an alias access. Each window is 0x02000000 bytes long. All other addresses are plain accesses.
- R2: The backing byte address keeps alias bits [31:29] and ORs in alias bits [24:0] shifted right by 5. Size encoding is 0 = byte, 1 = halfword, 2 = word. A halfword access clears address bit 0 and a word access clears bits [1:0]. Backing accesses use the same size code as the alias access.
- R3: The bit index comes from alias bits [6:2], masked to 3 bits for a byte, 4 bits for a halfword and 5 bits for a word. Index n selects bit n of the little-endian unit returned on `m_rdata`.
- R4: An alias read issues one backing read and returns 1 on `s_rdata` if the selected bit is set, otherwise 0. All upper result bits are zero.
- R5: An alias write uses only bit 0 of `s_wdata`: 1 sets the selected bit and 0 clears it. Bits [31:1] have no effect.
- R6: An alias write leaves every other bit of the backing unit unchanged.
- R7: An alias write is a backing read followed by a backing write at the same address and size. `m_lock` stays high from the read request until the write completes, and `s_done` pulses only when the write completes.
- R8: A plain access is issued once, with the master's address, size, direction and write data, and with `m_lock` low. Its read data is returned unchanged.
- R9: During reset and after it, with no request pending, `m_req`, `m_lock` and `s_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| s_req | input | 1 | master request, held until s_done |
| s_we | input | 1 | 1 = write |
| s_size | input | 2 | 0 byte, 1 halfword, 2 word |
| s_addr | input | 32 | access address |
| s_wdata | input | 32 | write data |
| s_done | output | 1 | one-cycle completion pulse |
| s_rdata | output | 32 | read result, valid with s_done |
| m_req | output | 1 | memory request |
| m_we | output | 1 | memory write |
| m_size | output | 2 | memory access size |
| m_addr | output | 32 | memory address |
| m_wdata | output | 32 | memory write data, low lanes |
| m_lock | output | 1 | bus lock for read-modify-write |
| m_done | input | 1 | memory completion pulse |
| m_rdata | input | 32 | memory read data, zero-extended |

## Verification
Alias reads are swept over both windows, all three sizes, 64 backing byte positions and all 32 index values. This separates index masking per size from alignment per size, and the two windows from each other. Alias writes alternate set and clear with junk in the upper write-data bits. A plain word read of the backing word after each write then shows whether only the one bit moved. Plain reads just outside each window edge tell the decode boundary from an off-by-one, and the phase trace of each access tells a locked two-phase update from a single-phase one.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } bb_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PASS = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } bb_state_e;
endpackage

// File: rtl/bb_decode.sv
module bb_decode
  import bb_pkg::*;
#(
  parameter int AW        = 32,
  parameter int NUM_WIN   = 2,
  parameter logic [NUM_WIN*AW-1:0] WIN_BASES = {32'h4200_0000, 32'h2200_0000},
  parameter int SPAN_LOG2 = 25,
  parameter int KEEP_W    = 3,
  parameter int IDX_W     = 5
) (
  input  logic [AW-1:0]    addr,
  input  logic [1:0]       size,
  output logic             hit,
  output logic [AW-1:0]    back_addr,
  output logic [IDX_W-1:0] bit_idx
);
  localparam int TAG_W = AW - SPAN_LOG2;

  logic [NUM_WIN-1:0]   hit_vec;
  logic [SPAN_LOG2-1:0] off;
  logic [AW-1:0]        raw;
  logic [IDX_W-1:0]     idx_full;

  // one tag comparator per window
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    assign hit_vec[g] = (addr[AW-1:SPAN_LOG2] == WIN_BASES[g*AW+SPAN_LOG2 +: TAG_W]);
  end
  assign hit = |hit_vec;

  assign off      = addr[SPAN_LOG2-1:0] >> IDX_W;
  assign raw      = {addr[AW-1 -: KEEP_W], {(AW-KEEP_W){1'b0}}} | AW'(off);
  assign idx_full = addr[IDX_W+1:2];

  always_comb begin
    case (bb_size_e'(size))
      SZ_BYTE: begin
        back_addr = raw;
        bit_idx   = idx_full & IDX_W'(7);
      end
      SZ_HALF: begin
        back_addr = raw & ~AW'(1);
        bit_idx   = idx_full & IDX_W'(15);
      end
      default: begin
        back_addr = raw & ~AW'(3);
        bit_idx   = idx_full;
      end
    endcase
  end
endmodule

// File: rtl/bb_bitop.sv
module bb_bitop #(
  parameter int DW    = 32,
  parameter int IDX_W = 5
) (
  input  logic [DW-1:0]    unit_in,
  input  logic [IDX_W-1:0] idx,
  input  logic             set_val,
  output logic             bit_out,
  output logic [DW-1:0]    unit_out
);
  logic [DW-1:0] sel;

  assign sel      = DW'(1) << idx;
  assign bit_out  = |(unit_in & sel);
  assign unit_out = set_val ? (unit_in | sel) : (unit_in & ~sel);
endmodule

// File: rtl/bb_bridge.sv
module bb_bridge
  import bb_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int NUM_WIN   = 2,
  parameter logic [NUM_WIN*AW-1:0] WIN_BASES = {32'h4200_0000, 32'h2200_0000},
  parameter int SPAN_LOG2 = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_req,
  input  logic          s_we,
  input  logic [1:0]    s_size,
  input  logic [AW-1:0] s_addr,
  input  logic [DW-1:0] s_wdata,
  output logic          s_done,
  output logic [DW-1:0] s_rdata,
  output logic          m_req,
  output logic          m_we,
  output logic [1:0]    m_size,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_wdata,
  output logic          m_lock,
  input  logic          m_done,
  input  logic [DW-1:0] m_rdata
);
  localparam int IDX_W  = $clog2(DW);
  localparam int KEEP_W = 3;

  // reset: asserted asynchronously, released on the clock
  logic rs_meta_n, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_n <= 1'b0;
      rs_n      <= 1'b0;
    end else begin
      rs_meta_n <= 1'b1;
      rs_n      <= rs_meta_n;
    end
  end

  // address decode on the incoming request
  logic             dec_hit;
  logic [AW-1:0]    dec_back;
  logic [IDX_W-1:0] dec_idx;

  bb_decode #(
    .AW(AW), .NUM_WIN(NUM_WIN), .WIN_BASES(WIN_BASES),
    .SPAN_LOG2(SPAN_LOG2), .KEEP_W(KEEP_W), .IDX_W(IDX_W)
  ) u_decode (
    .addr(s_addr), .size(s_size),
    .hit(dec_hit), .back_addr(dec_back), .bit_idx(dec_idx)
  );

  bb_state_e        st_q, st_d;
  logic             we_q;
  logic [1:0]       size_q;
  logic [AW-1:0]    addr_q;
  logic [AW-1:0]    back_q;
  logic [DW-1:0]    wdata_q;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    wmod_q;

  logic cap_en, wmod_en;
  logic bit_val;
  logic [DW-1:0] unit_mod;

  bb_bitop #(.DW(DW), .IDX_W(IDX_W)) u_bitop (
    .unit_in(m_rdata), .idx(idx_q), .set_val(wdata_q[0]),
    .bit_out(bit_val), .unit_out(unit_mod)
  );

  assign cap_en  = (st_q == ST_IDLE) && s_req;
  assign wmod_en = (st_q == ST_RD) && m_done && we_q;

  // next state
  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (s_req) st_d = dec_hit ? ST_RD : ST_PASS;
      ST_PASS: if (m_done) st_d = ST_IDLE;
      ST_RD:   if (m_done) st_d = we_q ? ST_WR : ST_IDLE;
      ST_WR:   if (m_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) st_q <= ST_IDLE;
    else       st_q <= st_d;
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      we_q    <= 1'b0;
      size_q  <= 2'd0;
      addr_q  <= '0;
      back_q  <= '0;
      wdata_q <= '0;
      idx_q   <= '0;
    end else if (cap_en) begin
      we_q    <= s_we;
      size_q  <= s_size;
      addr_q  <= s_addr;
      back_q  <= dec_back;
      wdata_q <= s_wdata;
      idx_q   <= dec_idx;
    end
  end

  // modified unit, enabled when the locked read returns
  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n)        wmod_q <= '0;
    else if (wmod_en) wmod_q <= unit_mod;
  end

  // master port
  always_comb begin
    m_req   = (st_q != ST_IDLE);
    m_size  = size_q;
    m_lock  = ((st_q == ST_RD) && we_q) || (st_q == ST_WR);
    if (st_q == ST_PASS) begin
      m_we    = we_q;
      m_addr  = addr_q;
      m_wdata = wdata_q;
    end else begin
      m_we    = (st_q == ST_WR);
      m_addr  = back_q;
      m_wdata = wmod_q;
    end
  end

  // slave response
  always_comb begin
    s_done  = 1'b0;
    s_rdata = '0;
    case (st_q)
      ST_PASS: begin
        s_done  = m_done;
        s_rdata = m_rdata;
      end
      ST_RD: begin
        s_done  = m_done && !we_q;
        s_rdata = we_q ? '0 : DW'(bit_val);
      end
      ST_WR: s_done = m_done;
      default: ;
    endcase
  end
endmodule

module bb_bridge_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_done,
  input logic          m_req,
  input logic          m_we,
  input logic [1:0]    m_size,
  input logic [AW-1:0] m_addr,
  input logic [DW-1:0] m_wdata,
  input logic          m_lock,
  input logic          m_done,
  input logic [DW-1:0] m_rdata
);
  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_lock && m_done && !m_we) |=> (m_req && m_lock && m_we));

  // R7
  same_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_lock && m_done && !m_we) |=> (m_addr == $past(m_addr) && m_size == $past(m_size)));

  // R6
  one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_lock && m_done && !m_we) |=> ($countones(m_wdata ^ $past(m_rdata)) <= 1));

  // R7
  done_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_done |-> m_done);

  // R9
  idle_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !m_req |-> !m_lock);
endmodule

bind bb_bridge bb_bridge_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_done(s_done), .m_req(m_req), .m_we(m_we),
  .m_size(m_size), .m_addr(m_addr), .m_wdata(m_wdata), .m_lock(m_lock),
  .m_done(m_done), .m_rdata(m_rdata)
);

// File: tb/bb_bridge_tb.sv
`timescale 1ns/1ps
module bb_bridge_tb;
  logic        clk, rst_n;
  logic        s_req, s_we, s_done;
  logic [1:0]  s_size, m_size;
  logic [31:0] s_addr, s_wdata, s_rdata, m_addr, m_wdata, m_rdata;
  logic        m_req, m_we, m_lock, m_done;

  int total, bad;

  bb_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .s_req(s_req), .s_we(s_we), .s_size(s_size),
    .s_addr(s_addr), .s_wdata(s_wdata), .s_done(s_done), .s_rdata(s_rdata),
    .m_req(m_req), .m_we(m_we), .m_size(m_size), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_lock(m_lock), .m_done(m_done), .m_rdata(m_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // memory model: 128 bytes per region, region chosen by address bit 30
  logic [7:0] mem [256];
  logic [7:0] exp_m [256];

  function automatic int ix(input logic [31:0] a);
    return {24'd0, a[30], a[6:0]};
  endfunction

  always_comb begin
    int i;
    i = ix(m_addr);
    case (m_size)
      2'd0:    m_rdata = {24'd0, mem[i]};
      2'd1:    m_rdata = {16'd0, mem[(i+1)%256], mem[i]};
      default: m_rdata = {mem[(i+3)%256], mem[(i+2)%256], mem[(i+1)%256], mem[i]};
    endcase
  end

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) m_done <= 1'b0;
    else        m_done <= m_req && !m_done;
  end

  always @(posedge clk) begin
    if (m_req && m_done && m_we) begin
      mem[ix(m_addr)] <= m_wdata[7:0];
      if (m_size != 2'd0) mem[(ix(m_addr)+1)%256] <= m_wdata[15:8];
      if (m_size == 2'd2) begin
        mem[(ix(m_addr)+2)%256] <= m_wdata[23:16];
        mem[(ix(m_addr)+3)%256] <= m_wdata[31:24];
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] ev);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, ev);
    end
  endtask

  // phase trace of the last access
  int          nph;
  logic        ph_we   [2];
  logic [31:0] ph_addr [2];
  logic [1:0]  ph_size [2];
  logic        lock_low_seen, lock_high_seen;

  task automatic acc(input logic we, input logic [1:0] sz, input logic [31:0] a,
                     input logic [31:0] wd, output logic [31:0] rd);
    int guard;
    nph = 0; lock_low_seen = 1'b0; lock_high_seen = 1'b0; rd = '0;
    @(negedge clk); #1;
    s_req = 1'b1; s_we = we; s_size = sz; s_addr = a; s_wdata = wd;
    guard = 0;
    while (1) begin
      @(negedge clk); #1;
      guard++;
      if (m_req && !m_lock) lock_low_seen = 1'b1;
      if (m_req && m_lock)  lock_high_seen = 1'b1;
      if (m_req && m_done && nph < 2) begin
        ph_we[nph] = m_we; ph_addr[nph] = m_addr; ph_size[nph] = m_size;
        nph++;
      end
      if (s_done) begin rd = s_rdata; break; end
      if (guard > 40) begin chk(1'b0, "R7 hang", 32'(guard), 0); break; end
    end
    s_req = 1'b0;
  endtask

  function automatic logic [31:0] unit_of(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] u;
    u = {a[31:29], 29'd0} | 32'(a[24:0] >> 5);
    if (sz == 2'd1) u[0] = 1'b0;
    if (sz == 2'd2) u[1:0] = 2'b00;
    return u;
  endfunction

  function automatic int bit_of(input logic [31:0] a, input logic [1:0] sz);
    int n;
    n = int'(a[6:2]);
    if (sz == 2'd0) n = n & 7;
    if (sz == 2'd1) n = n & 15;
    return n;
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] a);
    int i;
    i = ix({a[31:2], 2'b00});
    return {exp_m[i+3], exp_m[i+2], exp_m[i+1], exp_m[i]};
  endfunction

  initial begin
    repeat (195000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd, a, u, base, pa;
    int n, bi;
    total = 0; bad = 0;
    s_req = 0; s_we = 0; s_size = 0; s_addr = 0; s_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(!m_req && !m_lock && !s_done, "R9 reset idle", {m_req, m_lock, s_done}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(!m_req && !m_lock && !s_done, "R9 after reset", {m_req, m_lock, s_done}, 0);

    // fill both backing regions with plain byte writes
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < 128; i++) begin
        pa = (r == 0 ? 32'h2000_0000 : 32'h4000_0000) + 32'(i);
        exp_m[r*128+i] = 8'((i*37 + r*91 + 11) & 8'hff);
        acc(1'b1, 2'd0, pa, {24'hDEAD00, exp_m[r*128+i]}, rd);
        if (i == 5) begin
          chk(nph == 1 && ph_we[0] && ph_addr[0] == pa && ph_size[0] == 2'd0 && !lock_high_seen,
              "R8 plain write forwarded", ph_addr[0], pa);
        end
      end
    end
    acc(1'b0, 2'd2, 32'h2000_0010, 0, rd);
    chk(rd == exp_word(32'h2000_0010), "R8 plain read data", rd, exp_word(32'h2000_0010));

    // window edges: just outside must pass through untouched
    acc(1'b0, 2'd2, 32'h21FF_FFFC, 0, rd);
    chk(nph == 1 && ph_addr[0] == 32'h21FF_FFFC && rd == exp_word(32'h21FF_FFFC),
        "R1 below window 0", ph_addr[0], 32'h21FF_FFFC);
    acc(1'b0, 2'd2, 32'h2400_0000, 0, rd);
    chk(nph == 1 && ph_addr[0] == 32'h2400_0000 && rd == exp_word(32'h2400_0000),
        "R1 above window 0", ph_addr[0], 32'h2400_0000);
    acc(1'b0, 2'd2, 32'h41FF_FFFC, 0, rd);
    chk(nph == 1 && ph_addr[0] == 32'h41FF_FFFC, "R1 below window 1", ph_addr[0], 32'h41FF_FFFC);
    acc(1'b0, 2'd2, 32'h4400_0000, 0, rd);
    chk(nph == 1 && ph_addr[0] == 32'h4400_0000 && !lock_high_seen,
        "R8 above window 1", ph_addr[0], 32'h4400_0000);
    acc(1'b0, 2'd0, 32'h23FF_FFFC, 0, rd);
    chk(nph == 1 && ph_addr[0] == 32'h200F_FFFF, "R1 R2 last word of window 0", ph_addr[0], 32'h200F_FFFF);

    // alias read sweep
    for (int w = 0; w < 2; w++) begin
      base = (w == 0) ? 32'h2200_0000 : 32'h4200_0000;
      for (int sz = 0; sz < 3; sz++) begin
        for (int bk = 0; bk < 64; bk++) begin
          for (int k = 0; k < 32; k++) begin
            a  = base | (32'(bk) << 5) | (32'(k) << 2);
            u  = unit_of(a, 2'(sz));
            n  = bit_of(a, 2'(sz));
            bi = ix(u) + n / 8;
            acc(1'b0, 2'(sz), a, 32'hFFFF_FFFF, rd);
            chk(rd == {31'd0, exp_m[bi][n%8]}, "R3 R4 alias read bit", rd, {31'd0, exp_m[bi][n%8]});
            chk(nph == 1 && !ph_we[0] && ph_addr[0] == u && ph_size[0] == 2'(sz),
                "R2 alias read unit address", ph_addr[0], u);
          end
        end
      end
    end

    // alias write sweep: set/clear with junk above bit 0
    for (int w = 0; w < 2; w++) begin
      base = (w == 0) ? 32'h2200_0000 : 32'h4200_0000;
      for (int sz = 0; sz < 3; sz++) begin
        for (int bk = 0; bk < 64; bk += 3) begin
          for (int k = 0; k < 32; k++) begin
            logic v;
            logic [31:0] wd;
            v  = 1'((bk + k + sz) & 1);
            wd = {31'(bk * 2654435 + k * 40503), v};
            a  = base | (32'(bk) << 5) | (32'(k) << 2);
            u  = unit_of(a, 2'(sz));
            n  = bit_of(a, 2'(sz));
            bi = ix(u) + n / 8;
            exp_m[bi][n%8] = v;
            acc(1'b1, 2'(sz), a, wd, rd);
            chk(nph == 2 && !ph_we[0] && ph_we[1] && ph_addr[0] == u && ph_addr[1] == u
                && ph_size[0] == 2'(sz) && ph_size[1] == 2'(sz),
                "R7 read then write same unit", ph_addr[1], u);
            chk(!lock_low_seen && lock_high_seen, "R7 lock held", {lock_low_seen, lock_high_seen}, 1);
            acc(1'b0, 2'd2, {u[31:2], 2'b00}, 0, rd);
            chk(rd == exp_word(u), "R5 R6 backing word after write", rd, exp_word(u));
          end
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule